// File: doc/BRIEF.md
# Single-Shot Two-Unit Conversion Sequencer

This block runs one on-demand analog-to-digital conversion on either of two converter units (unit A or unit B) that sit behind a slower, divided controller clock. A requester presents a unit select and a 4-bit channel number with a one-cycle request. The sequencer latches them and clears the stale done flag of the chosen unit. It then routes the one-time sample enable to that unit alone and drives the channel number. Next it holds the start control low long enough for the slow controller clock to capture the edge, and raises it again.

The sequencer then waits for the chosen unit's done flag, captures the 12-bit raw code and presents it with a one-cycle valid pulse. A reading from unit B is screened for validity: the converter reports a rejected unit B conversion as the all-ones code, and the sequencer turns that into an error status. The low-phase length is held in a register that reset loads from a value computed from the divider ratio parameter.

Top module: `adc_oneshot_seq`

## Requirements
- R1: Out of reset and whenever idle, busy is low, the start control is high, both sample enables are low and no clear is driven.
- R2: The cycle after a request is accepted, the chosen unit's bit of the clear output (bit 0 = unit A, bit 1 = unit B) is high for exactly one cycle while both sample enables are low.
- R3: After the clear, only the chosen unit's sample enable is high, with the conversion channel output equal to the requested channel. The enable stays high until the result is captured and is low in the cycle the result is presented.
- R4: The start control is low for exactly 3*DIV_RATIO clock cycles when DIV_RATIO is greater than 8, and for 1 cycle otherwise, and then returns high.
- R5: The sequencer completes only on the chosen unit's done bit (bit 0 = unit A, bit 1 = unit B). A done bit that is still set on the other unit is ignored.
- R6: On the chosen done bit, the chosen unit's raw code is presented on the result output with a valid pulse exactly one cycle wide.
- R7: A unit B code of 12'hFFF is reported with the error output high. Any other unit B code, and every unit A code including 12'hFFF, is reported with the error output low.
- R8: Busy is high from the cycle after an accepted request until the cycle the valid pulse appears, where it is low. Requests that arrive while busy are ignored.
- R9: A done flag left set by an earlier conversion on the same unit does not end the new conversion early: the result is the one from the new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Conversion request, one cycle |
| req_unit | input | 1 | Unit select: 0 = unit A, 1 = unit B |
| req_chan | input | 4 | Channel number for the conversion |
| busy | output | 1 | Conversion in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 12 | Captured raw code |
| rsp_err | output | 1 | Unit B reading rejected |
| cv_clr | output | 2 | Done-flag clear per unit |
| cv_en | output | 2 | One-time sample enable per unit |
| cv_chan | output | 4 | Channel driven to the converter |
| cv_start | output | 1 | Start control, low then high |
| cv_done | input | 2 | Sticky done flags per unit |
| cv_raw_a | input | 12 | Unit A raw code |
| cv_raw_b | input | 12 | Unit B raw code |

## Verification
The hardest condition to reach is a done flag that is already set when a conversion begins. The converter model keeps its done flags sticky until cleared. The sweep therefore runs back-to-back conversions on the same unit, and alternates units so that the other unit's flag stays set throughout a conversion. A sequencer that skipped the clear, or looked at the wrong bit, would then return the previous code. The model also refuses any start edge whose low phase is shorter than its minimum and reports the measured low width. A second instance with a fast divider covers the single-cycle case, and stray requests injected mid-conversion probe the busy lockout.

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq #(
  parameter int DIV_RATIO = 10,
  parameter int CHAN_W    = 4,
  parameter int RAW_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_unit,
  input  logic [CHAN_W-1:0] req_chan,
  output logic              busy,
  output logic              rsp_valid,
  output logic [RAW_W-1:0]  rsp_data,
  output logic              rsp_err,
  output logic [1:0]        cv_clr,
  output logic [1:0]        cv_en,
  output logic [CHAN_W-1:0] cv_chan,
  output logic              cv_start,
  input  logic [1:0]        cv_done,
  input  logic [RAW_W-1:0]  cv_raw_a,
  input  logic [RAW_W-1:0]  cv_raw_b
);
  localparam int LOW_CYC = (DIV_RATIO > 8) ? 3 * DIV_RATIO : 1;
  localparam int CNT_W   = $clog2(LOW_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ARM, S_LOW, S_WAIT} state_t;

  state_t            st;
  logic              unit_q;
  logic [CHAN_W-1:0] chan_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  low_len;
  logic [1:0]        sel;

  assign sel      = unit_q ? 2'b10 : 2'b01;
  assign busy     = (st != S_IDLE);
  assign cv_clr   = (st == S_CLR) ? sel : 2'b00;
  assign cv_en    = (st == S_ARM || st == S_LOW || st == S_WAIT) ? sel : 2'b00;
  assign cv_start = (st != S_LOW);
  assign cv_chan  = chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      unit_q    <= 1'b0;
      chan_q    <= '0;
      cnt       <= '0;
      low_len   <= CNT_W'(LOW_CYC - 1);
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          unit_q <= req_unit;
          chan_q <= req_chan;
          st     <= S_CLR;
        end
        S_CLR: st <= S_ARM;
        S_ARM: begin
          cnt <= low_len;
          st  <= S_LOW;
        end
        S_LOW: begin
          if (cnt == '0) st <= S_WAIT;
          else           cnt <= cnt - 1'b1;
        end
        S_WAIT: if (cv_done[unit_q]) begin
          rsp_valid <= 1'b1;
          rsp_data  <= unit_q ? cv_raw_b : cv_raw_a;
          rsp_err   <= unit_q && (cv_raw_b == '1);
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_oneshot_seq_chk.sv
module adc_oneshot_seq_chk #(
  parameter int DIV_RATIO = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rsp_valid,
  input logic [1:0] cv_clr,
  input logic [1:0] cv_en,
  input logic       cv_start
);
  localparam int LOW_CYC = (DIV_RATIO > 8) ? 3 * DIV_RATIO : 1;

  int unsigned low_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_seen <= 0;
    else if (cv_start) low_seen <= 0;
    else               low_seen <= low_seen + 1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cv_start && cv_en == 2'b00 && cv_clr == 2'b00));

  a_r2_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_clr != 2'b00) |-> (cv_en == 2'b00 && $countones(cv_clr) == 1));

  a_r2_clear_then_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_clr != 2'b00) |=> (cv_en == $past(cv_clr)));

  a_r3_enable_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cv_en));

  a_r3_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cv_en == 2'b00));

  a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_start) |-> (low_seen == LOW_CYC));

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_busy_ends_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
endmodule

bind adc_oneshot_seq adc_oneshot_seq_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .cv_clr(cv_clr), .cv_en(cv_en), .cv_start(cv_start)
);

// File: tb/adc_oneshot_seq_tb.sv
module adc_conv_model #(
  parameter int MIN_LOW = 1,
  parameter int LAT     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  clr,
  input  logic [1:0]  en,
  input  logic [3:0]  chan,
  input  logic        start,
  input  logic        bad,
  output logic [1:0]  done,
  output logic [11:0] raw_a,
  output logic [11:0] raw_b,
  output int          last_low
);
  int lowcnt, timer;
  logic start_q, pend, punit, pbad;
  logic [3:0] pchan;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= 0; timer <= 0; start_q <= 1'b1; pend <= 1'b0;
      punit <= 1'b0; pbad <= 1'b0; pchan <= '0;
      done <= 2'b00; raw_a <= '0; raw_b <= '0; last_low <= 0;
    end else begin
      start_q <= start;
      lowcnt  <= start ? 0 : lowcnt + 1;
      if (start && !start_q) begin
        last_low <= lowcnt;
        if (lowcnt >= MIN_LOW && en != 2'b00) begin
          pend <= 1'b1; timer <= LAT; punit <= en[1]; pchan <= chan; pbad <= bad;
        end
      end
      if (pend) begin
        if (timer == 0) begin
          pend <= 1'b0;
          done[punit] <= 1'b1;
          if (punit) raw_b <= pbad ? 12'hFFF : 12'((int'(pchan) * 149 + 1007) % 4096);
          else       raw_a <= pbad ? 12'hFFF : 12'((int'(pchan) * 149 + 7) % 4096);
        end else timer <= timer - 1;
      end
      if (clr[0]) done[0] <= 1'b0;
      if (clr[1]) done[1] <= 1'b0;
    end
  end
endmodule

module adc_oneshot_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_s = 1'b0, req_f = 1'b0, unit_i = 1'b0, bad_i = 1'b0;
  logic [3:0] chan_i = '0;

  logic busy_s, val_s, err_s, start_s, busy_f, val_f, err_f, start_f;
  logic [11:0] data_s, data_f, ra_s, rb_s, ra_f, rb_f;
  logic [1:0] clr_s, en_s, done_s, clr_f, en_f, done_f;
  logic [3:0] ch_s, ch_f;
  int low_s, low_f;

  adc_oneshot_seq #(.DIV_RATIO(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req_s), .req_unit(unit_i), .req_chan(chan_i),
    .busy(busy_s), .rsp_valid(val_s), .rsp_data(data_s), .rsp_err(err_s),
    .cv_clr(clr_s), .cv_en(en_s), .cv_chan(ch_s), .cv_start(start_s),
    .cv_done(done_s), .cv_raw_a(ra_s), .cv_raw_b(rb_s));
  adc_conv_model #(.MIN_LOW(30)) u_mod_s (
    .clk(clk), .rst_n(rst_n), .clr(clr_s), .en(en_s), .chan(ch_s), .start(start_s),
    .bad(bad_i), .done(done_s), .raw_a(ra_s), .raw_b(rb_s), .last_low(low_s));

  adc_oneshot_seq #(.DIV_RATIO(4)) u_dut_fast (
    .clk(clk), .rst_n(rst_n), .req(req_f), .req_unit(unit_i), .req_chan(chan_i),
    .busy(busy_f), .rsp_valid(val_f), .rsp_data(data_f), .rsp_err(err_f),
    .cv_clr(clr_f), .cv_en(en_f), .cv_chan(ch_f), .cv_start(start_f),
    .cv_done(done_f), .cv_raw_a(ra_f), .cv_raw_b(rb_f));
  adc_conv_model #(.MIN_LOW(1)) u_mod_f (
    .clk(clk), .rst_n(rst_n), .clr(clr_f), .en(en_f), .chan(ch_f), .start(start_f),
    .bad(bad_i), .done(done_f), .raw_a(ra_f), .raw_b(rb_f), .last_low(low_f));

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_code(input int u, input int c, input bit b);
    if (b) return 4095;
    return (c * 149 + u * 1000 + 7) % 4096;
  endfunction

  task automatic conv(input bit fast, input int u, input int c, input bit b, input bit stray);
    int exp_low, n;
    bit seen;
    exp_low = fast ? 1 : 30;
    @(negedge clk);
    unit_i = u[0]; chan_i = c[3:0]; bad_i = b;
    if (fast) req_f = 1'b1; else req_s = 1'b1;
    @(negedge clk);
    req_f = 1'b0; req_s = 1'b0;
    check("R8 busy after accept", fast ? busy_f : busy_s, 1);
    check("R2 clear bit", fast ? clr_f : clr_s, u ? 2 : 1);
    check("R2 enables low during clear", fast ? en_f : en_s, 0);
    @(negedge clk);
    check("R3 only chosen enable", fast ? en_f : en_s, u ? 2 : 1);
    check("R3 channel driven", fast ? ch_f : ch_s, c);
    seen = 1'b0;
    for (n = 0; n < 500 && !seen; n++) begin
      if (stray && n == 3) begin
        unit_i = ~u[0]; chan_i = c[3:0] ^ 4'h5;
        if (fast) req_f = 1'b1; else req_s = 1'b1;
      end else begin
        req_f = 1'b0; req_s = 1'b0;
      end
      if (fast ? val_f : val_s) seen = 1'b1;
      else @(negedge clk);
    end
    req_f = 1'b0; req_s = 1'b0;
    check("R6 valid seen", seen, 1);
    check("R9 R5 result code", fast ? data_f : data_s, expect_code(u, c, b));
    check("R7 error status", fast ? err_f : err_s, (u == 1 && b) ? 1 : 0);
    check("R8 busy low at valid", fast ? busy_f : busy_s, 0);
    check("R3 enable dropped", fast ? en_f : en_s, 0);
    check("R4 start low width", fast ? low_f : low_s, exp_low);
    @(negedge clk);
    check("R6 valid one cycle", fast ? val_f : val_s, 0);
    check("R8 stray request ignored", fast ? busy_f : busy_s, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy_s, 0);
    check("R1 reset start high", start_s, 1);
    check("R1 reset enables", en_s, 0);
    check("R1 reset clear", clr_s, 0);
    check("R1 reset valid", val_s, 0);
    check("R1 reset fast start", start_f, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {busy_s, en_s, clr_s, start_s}, 1);
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c++)
        for (int u = 0; u < 2; u++) begin
          conv(1'b0, u, c, b[0], (c % 4) == 1);
          conv(1'b0, u, c ^ 3, b[0], 1'b0);
        end
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c += 5)
        for (int u = 0; u < 2; u++)
          conv(1'b1, u, c, b[0], c == 5);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule